// File: doc/BRIEF.md
# Configuration Readback Serial Streamer

This block sends a stored configuration image out on one serial line once a trigger arrives. It fetches the image bits one at a time through a synchronous read port with one cycle of latency. It wraps those bits in a fixed framing. The stream opens with a run of high dummy bits. Each frame starts with a low start bit and closes with high error-check filler bits. Certain data positions are always sent high. After the last frame comes a closing low start bit and an 11-bit CRC signature. A read-in-progress flag stays high for the whole transfer.

The frame count, data bits per frame, dummy count, check-bit count, forced-high spans and CRC polynomial are all parameters. With the defaults (4 frames of 16 data bits), a transfer carries 101 serial bits. Data goes out with the polarity it was stored with. The CRC covers the data bits exactly as they appear on the line, forced positions included.

Top module: `readback_streamer`

## Requirements
- R1: While reset is asserted and just after its release, `rip_o` is low, `sdata_o` is high and `rd_en_o` is low.
- R2: When idle and armed, a high level on `trig_i` at a rising edge raises `rip_o` on that same edge. From the next edge on, every edge places exactly one new bit on `sdata_o`.
- R3: The first five bits of a transfer are high dummy bits, and no preamble comes before them.
- R4: Each frame starts with one low start bit, followed by 16 data bits and then 4 high check bits. The first frame follows straight after the dummies.
- R5: Data bit b of frame f is read at address f*16+b, with `rd_en_o` high in the cycle before the read data is used. It is sent without inversion. Forced-high positions issue no read, so a transfer makes 59 reads.
- R6: Data bits 0 and 1 of frame 0 are always sent high, whatever is stored.
- R7: The last seven bits of the last frame (its last three data bits and four check bits) are always sent high.
- R8: After the last frame comes one low start bit and then 11 CRC bits, most significant first. The CRC starts at zero and takes in every transmitted data bit in order, forced positions included. For each data bit d: fb = crc[10] xor d; crc = (crc << 1) xor (fb ? 0x307 : 0).
- R9: `rip_o` stays high through the last CRC bit and falls on the next edge. Whenever `rip_o` is low, `sdata_o` is high.
- R10: A trigger while `rip_o` is high is ignored. A new transfer starts only after `trig_i` has been sampled low while idle and then high again, so `rip_o` stays low for at least one cycle after it falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readback clock; all bits shift on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Readback trigger, level sampled |
| rd_en_o | output | 1 | Read strobe to the image storage |
| rd_addr_o | output | 6 | Bit address, frame*16 + bit |
| rd_data_i | input | 1 | Stored bit, valid one cycle after the strobe |
| sdata_o | output | 1 | Serial readback data |
| rip_o | output | 1 | Read-in-progress flag |

## Verification
The end of a transfer and a fresh trigger can land on the same edge: `rip_o` falls on the very edge where `trig_i` is high. The bench provokes this by toggling the trigger during a transfer and then holding it high across the falling edge and for many cycles after. It judges against a behavioural model that arms only after a low sample while idle, so `rip_o` must stay low until the trigger drops and rises again. A second overlap is a forced-high position whose value must still enter the CRC. Stored images of all zeros, all ones and a mixed pattern make a skipped CRC update visible in the signature.

// File: rtl/rb_pkg.sv
`timescale 1ns/1ps
package rb_pkg;
  localparam int CRC_W = 11;

  typedef enum logic [2:0] {
    K_ONE    = 3'd0,
    K_ZERO   = 3'd1,
    K_MEM    = 3'd2,
    K_FORCED = 3'd3,
    K_CRC    = 3'd4
  } bit_kind_e;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_DUMMY  = 3'd1,
    PH_START  = 3'd2,
    PH_DATA   = 3'd3,
    PH_CHECK  = 3'd4,
    PH_FSTART = 3'd5,
    PH_CRC    = 3'd6
  } phase_e;

  function automatic logic [CRC_W-1:0] crc_step(
    input logic [CRC_W-1:0] crc,
    input logic [CRC_W-1:0] poly,
    input logic             din
  );
    logic fb;
    fb = crc[CRC_W-1] ^ din;
    return {crc[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
  endfunction
endpackage

// File: rtl/rb_trig.sv
`timescale 1ns/1ps
module rb_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic idle_i,
  output logic start_o
);
  logic armed_q, armed_d;

  assign start_o = idle_i & armed_q & trig_i;

  always_comb begin
    armed_d = armed_q;
    if (start_o)
      armed_d = 1'b0;
    else if (idle_i && !trig_i)
      armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end
endmodule

// File: rtl/rb_seq.sv
`timescale 1ns/1ps
module rb_seq #(
  parameter int NUM_FRAMES = 4,
  parameter int FRAME_BITS = 16,
  parameter int DUMMY_BITS = 5,
  parameter int CHECK_BITS = 4,
  parameter int HEAD_HIGH  = 2,
  parameter int TAIL_HIGH  = 7,
  parameter int AW         = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  output logic               load_o,
  output rb_pkg::bit_kind_e  kind_o,
  output logic               rd_en_o,
  output logic [AW-1:0]      rd_addr_o,
  output logic               idle_o
);
  import rb_pkg::*;

  localparam int TAIL_DATA = TAIL_HIGH - CHECK_BITS;
  localparam int MAXA = (FRAME_BITS > DUMMY_BITS) ? FRAME_BITS : DUMMY_BITS;
  localparam int MAXB = (CHECK_BITS > CRC_W) ? CHECK_BITS : CRC_W;
  localparam int MAXC = (MAXA > MAXB) ? MAXA : MAXB;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int FW   = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1;

  localparam logic [CW-1:0] LAST_DUMMY = CW'(DUMMY_BITS - 1);
  localparam logic [CW-1:0] LAST_DATA  = CW'(FRAME_BITS - 1);
  localparam logic [CW-1:0] LAST_CHECK = CW'(CHECK_BITS - 1);
  localparam logic [CW-1:0] LAST_CRC   = CW'(CRC_W - 1);
  localparam logic [CW-1:0] HEAD_END   = CW'(HEAD_HIGH);
  localparam logic [CW-1:0] TAIL_BEG   = CW'(FRAME_BITS - TAIL_DATA);
  localparam logic [FW-1:0] LAST_FRAME = FW'(NUM_FRAMES - 1);

  phase_e          phase_q, phase_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [FW-1:0]   frm_q, frm_d;
  logic            adv;
  logic            forced;

  assign idle_o    = (phase_q == PH_IDLE);
  assign adv       = !idle_o || start_i;
  assign forced    = ((frm_q == '0) && (cnt_q < HEAD_END)) ||
                     ((frm_q == LAST_FRAME) && (cnt_q >= TAIL_BEG));
  assign rd_addr_o = AW'(frm_q) * AW'(FRAME_BITS) + AW'(cnt_q);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    frm_d   = frm_q;
    load_o  = 1'b1;
    kind_o  = K_ONE;
    rd_en_o = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        load_o = start_i;
        if (start_i) begin
          phase_d = PH_DUMMY;
          cnt_d   = CW'(1);
        end
      end
      PH_DUMMY: begin
        if (cnt_q == LAST_DUMMY) begin
          phase_d = PH_START;
          cnt_d   = '0;
          frm_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_START: begin
        kind_o  = K_ZERO;
        phase_d = PH_DATA;
        cnt_d   = '0;
      end
      PH_DATA: begin
        kind_o  = forced ? K_FORCED : K_MEM;
        rd_en_o = !forced;
        if (cnt_q == LAST_DATA) begin
          phase_d = PH_CHECK;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_CHECK: begin
        if (cnt_q == LAST_CHECK) begin
          cnt_d = '0;
          if (frm_q == LAST_FRAME) begin
            phase_d = PH_FSTART;
          end else begin
            frm_d   = frm_q + 1'b1;
            phase_d = PH_START;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_FSTART: begin
        kind_o  = K_ZERO;
        phase_d = PH_CRC;
        cnt_d   = '0;
      end
      PH_CRC: begin
        kind_o = K_CRC;
        if (cnt_q == LAST_CRC) begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        load_o  = 1'b0;
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      frm_q   <= '0;
    end else if (adv) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      frm_q   <= frm_d;
    end
  end
endmodule

// File: rtl/rb_out.sv
`timescale 1ns/1ps
module rb_out #(
  parameter logic [rb_pkg::CRC_W-1:0] CRC_POLY = 11'h307
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              load_i,
  input  rb_pkg::bit_kind_e kind_i,
  input  logic              rd_data_i,
  input  logic              seq_idle_i,
  output logic              sdata_o,
  output logic              rip_o
);
  import rb_pkg::*;

  logic             v1_q, v1_d;
  bit_kind_e        kind1_q, kind1_d;
  logic             sdata_q, sdata_d;
  logic [CRC_W-1:0] crc_q, crc_d;
  logic             rip_q, rip_d;
  logic             bit_val;
  logic             crc_en;

  assign sdata_o = sdata_q;
  assign rip_o   = rip_q;
  assign crc_en  = start_i || v1_q;

  always_comb begin
    case (kind1_q)
      K_ONE:    bit_val = 1'b1;
      K_ZERO:   bit_val = 1'b0;
      K_MEM:    bit_val = rd_data_i;
      K_FORCED: bit_val = 1'b1;
      K_CRC:    bit_val = crc_q[CRC_W-1];
      default:  bit_val = 1'b1;
    endcase
  end

  always_comb begin
    v1_d    = load_i;
    kind1_d = load_i ? kind_i : kind1_q;
    sdata_d = v1_q ? bit_val : 1'b1;
    crc_d   = crc_q;
    if (start_i)
      crc_d = '0;
    else if (v1_q && (kind1_q == K_MEM || kind1_q == K_FORCED))
      crc_d = crc_step(crc_q, CRC_POLY, bit_val);
    else if (v1_q && kind1_q == K_CRC)
      crc_d = {crc_q[CRC_W-2:0], 1'b0};
    rip_d = rip_q;
    if (start_i)
      rip_d = 1'b1;
    else if (rip_q && !v1_q && seq_idle_i)
      rip_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q    <= 1'b0;
      kind1_q <= K_ONE;
      sdata_q <= 1'b1;
      rip_q   <= 1'b0;
    end else begin
      v1_q    <= v1_d;
      kind1_q <= kind1_d;
      sdata_q <= sdata_d;
      rip_q   <= rip_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= '0;
    else if (crc_en) crc_q <= crc_d;
  end
endmodule

// File: rtl/readback_streamer.sv
`timescale 1ns/1ps
module readback_streamer #(
  parameter int NUM_FRAMES = 4,
  parameter int FRAME_BITS = 16,
  parameter int DUMMY_BITS = 5,
  parameter int CHECK_BITS = 4,
  parameter int HEAD_HIGH  = 2,
  parameter int TAIL_HIGH  = 7,
  parameter logic [10:0] CRC_POLY = 11'h307,
  localparam int AW = $clog2(NUM_FRAMES * FRAME_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_i,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_data_i,
  output logic          sdata_o,
  output logic          rip_o
);
  logic              start;
  logic              load;
  logic              seq_idle;
  rb_pkg::bit_kind_e kind;

  rb_trig u_trig (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig_i (trig_i),
    .idle_i (seq_idle && !rip_o),
    .start_o(start)
  );

  rb_seq #(
    .NUM_FRAMES(NUM_FRAMES),
    .FRAME_BITS(FRAME_BITS),
    .DUMMY_BITS(DUMMY_BITS),
    .CHECK_BITS(CHECK_BITS),
    .HEAD_HIGH (HEAD_HIGH),
    .TAIL_HIGH (TAIL_HIGH),
    .AW        (AW)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start),
    .load_o   (load),
    .kind_o   (kind),
    .rd_en_o  (rd_en_o),
    .rd_addr_o(rd_addr_o),
    .idle_o   (seq_idle)
  );

  rb_out #(
    .CRC_POLY(CRC_POLY)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .load_i    (load),
    .kind_i    (kind),
    .rd_data_i (rd_data_i),
    .seq_idle_i(seq_idle),
    .sdata_o   (sdata_o),
    .rip_o     (rip_o)
  );
endmodule

// File: rtl/readback_streamer_chk.sv
`timescale 1ns/1ps
module readback_streamer_chk #(
  parameter int NUM_FRAMES = 4,
  parameter int FRAME_BITS = 16,
  parameter int CHECK_BITS = 4,
  parameter int HEAD_HIGH  = 2,
  parameter int TAIL_HIGH  = 7,
  parameter int AW         = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trig_i,
  input logic          rd_en_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          sdata_o,
  input logic          rip_o
);
  localparam int EXP_READS = NUM_FRAMES * FRAME_BITS - HEAD_HIGH - (TAIL_HIGH - CHECK_BITS);
  localparam int TOTAL     = NUM_FRAMES * FRAME_BITS;

  logic [15:0] rd_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_cnt <= '0;
    else if (!rip_o)  rd_cnt <= '0;
    else if (rd_en_o) rd_cnt <= rd_cnt + 16'd1;
  end

  // R9
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rip_o |-> sdata_o);

  // R2
  start_needs_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rip_o) |-> $past(trig_i));

  // R3
  first_dummy_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rip_o) |=> sdata_o);

  // R10
  no_quick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rip_o) |=> !rip_o);

  // R5
  read_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |-> (rip_o && ({1'b0, rd_addr_o} < (AW+1)'(TOTAL))));

  // R5
  read_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rip_o) |-> (rd_cnt == 16'(EXP_READS)));
endmodule

bind readback_streamer readback_streamer_chk #(
  .NUM_FRAMES(NUM_FRAMES),
  .FRAME_BITS(FRAME_BITS),
  .CHECK_BITS(CHECK_BITS),
  .HEAD_HIGH (HEAD_HIGH),
  .TAIL_HIGH (TAIL_HIGH),
  .AW        (AW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .trig_i   (trig_i),
  .rd_en_o  (rd_en_o),
  .rd_addr_o(rd_addr_o),
  .sdata_o  (sdata_o),
  .rip_o    (rip_o)
);

// File: tb/readback_streamer_tb.sv
`timescale 1ns/1ps
module readback_streamer_tb;
  localparam int NF = 4;
  localparam int FB = 16;
  localparam int MB = NF * FB;
  localparam logic [10:0] POLY = 11'h307;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       trig;
  logic       rd_en;
  logic [5:0] rd_addr;
  logic       rd_data;
  logic       sdata;
  logic       rip;

  logic mem [MB];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   cmp_en   = 1'b0;

  always #5 clk = ~clk;

  readback_streamer u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_i   (trig),
    .rd_en_o  (rd_en),
    .rd_addr_o(rd_addr),
    .rd_data_i(rd_data),
    .sdata_o  (sdata),
    .rip_o    (rip)
  );

  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  logic  exp_q[$];
  string tag_q[$];

  function automatic void build();
    logic [10:0] crc = '0;
    logic        d;
    exp_q.delete(); tag_q.delete();
    for (int i = 0; i < 5; i++) begin exp_q.push_back(1'b1); tag_q.push_back("R3"); end
    for (int f = 0; f < NF; f++) begin
      exp_q.push_back(1'b0); tag_q.push_back("R4");
      for (int b = 0; b < FB; b++) begin
        if (f == 0 && b < 2) begin d = 1'b1; tag_q.push_back("R6"); end
        else if (f == NF-1 && b >= FB-3) begin d = 1'b1; tag_q.push_back("R7"); end
        else begin d = mem[f*FB+b]; tag_q.push_back("R5"); end
        exp_q.push_back(d);
        crc = {crc[9:0], 1'b0} ^ ((crc[10] ^ d) ? POLY : 11'h000);
      end
      for (int c = 0; c < 4; c++) begin
        exp_q.push_back(1'b1); tag_q.push_back((f == NF-1) ? "R7" : "R4");
      end
    end
    exp_q.push_back(1'b0); tag_q.push_back("R8");
    for (int i = 10; i >= 0; i--) begin exp_q.push_back(crc[i]); tag_q.push_back("R8"); end
  endfunction

  logic  m_rip, m_sd, m_armed;
  int    m_k;
  string m_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rip = 1'b0; m_sd = 1'b1; m_armed = 1'b0; m_k = 0; m_tag = "R1";
    end else if (m_rip) begin
      if (m_k < exp_q.size()) begin
        m_sd = exp_q[m_k]; m_tag = tag_q[m_k]; m_k++;
      end else begin
        m_rip = 1'b0; m_sd = 1'b1; m_tag = "R9";
      end
    end else if (m_armed && trig) begin
      build(); m_rip = 1'b1; m_k = 0; m_armed = 1'b0; m_tag = "R2";
    end else if (!trig) begin
      m_armed = 1'b1;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      check(m_rip ? (m_k == 0 ? "R2" : "R9") : "R10", rip, m_rip);
      check(m_tag, sdata, m_sd);
    end
  end

  task automatic run(input int cycles);
    repeat (cycles) @(negedge clk);
  endtask

  initial begin
    #200000;
    n_fail++; n_checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; trig = 1'b0;
    for (int i = 0; i < MB; i++) mem[i] = 1'b0;
    run(3);
    check("R1", rip, 1'b0);
    check("R1", sdata, 1'b1);
    check("R1", rd_en, 1'b0);
    rst_n = 1'b1;
    run(1);
    check("R1", rip, 1'b0);
    cmp_en = 1'b1;
    run(2);
    // all-zero image: forced positions and CRC over them
    trig = 1'b1; run(2); trig = 1'b0;
    run(110);
    // all-ones image
    for (int i = 0; i < MB; i++) mem[i] = 1'b1;
    trig = 1'b1; run(1); trig = 1'b0;
    run(110);
    // mixed image, trigger toggled mid-transfer and held across the end (R10)
    for (int i = 0; i < MB; i++) mem[i] = logic'(((i * 13) ^ (i >> 2) ^ (i / 5)) & 1);
    trig = 1'b1; run(2);
    for (int t = 0; t < 6; t++) begin trig = ~trig; run(7); end
    trig = 1'b1;
    run(90);
    run(20);
    trig = 1'b0; run(3);
    trig = 1'b1; run(4); trig = 1'b0;
    run(110);
    cmp_en = 1'b0;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule